// File: doc/BRIEF.md
# Floating-Point Status Flag Register with Masked Update

This block keeps the exception status of a floating-point unit. It holds five flags: invalid operation, overflow, divide-by-zero, underflow, and a summary flag that records that some exception has happened. It also holds one separate inexact-status bit. Arithmetic units report new exceptions through per-flag set inputs. Each set input ORs into its flag, so a flag stays set until something overwrites it.

Software or a sequencer can also rewrite the flags with a single 32-bit update word. One byte of the word carries the new flag values. The byte directly above it carries an enable mask with the same bit layout. Each of the five flags takes the AND of its value bit and its enable bit. The inexact-status bit works differently: it is rewritten only when its enable bit is set, and otherwise it keeps its old value.

Top module: `fpu_status_flags`

## Requirements
- R1: While rst_ni is low, flags_o and inexact_o are all zero.
- R2: In an update cycle (upd_valid_i high), after the next rising edge flags_o[k] equals upd_word_i[3+k] AND upd_word_i[11+k], for k = 0 to 4. The flag order is k=0 underflow, k=1 divide-by-zero, k=2 overflow, k=3 invalid, k=4 summary.
- R3: An update whose enable bit for a flag is 0 clears that flag, even if its value bit is 1 and even if the flag was set before.
- R4: An update with upd_word_i[10] = 1 loads inexact_o with upd_word_i[2].
- R5: An update with upd_word_i[10] = 0 leaves inexact_o unchanged.
- R6: Outside update cycles, exc_set_i[j] ORs into flags_o[j] (j = 0 underflow, 1 divide-by-zero, 2 overflow, 3 invalid), and inexact_set_i ORs into inexact_o. A flag with no set input keeps its value.
- R7: Outside update cycles, any asserted bit of exc_set_i or inexact_set_i also sets the summary flag flags_o[4].
- R8: In an update cycle, every set input is ignored. Only the update word decides the next state.
- R9: Update-word bits other than 2 through 7 and 10 through 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Strobe that applies upd_word_i at the next edge |
| upd_word_i | input | 32 | Flag values and enable mask |
| exc_set_i | input | 4 | Exception set pulses from the arithmetic units |
| inexact_set_i | input | 1 | Inexact set pulse |
| flags_o | output | 5 | {summary, invalid, overflow, divzero, underflow} |
| inexact_o | output | 1 | Inexact-status bit |

## Verification
The hardest situation to reach is an update that arrives in the same cycle as set pulses, where the flags it masks off are already set. The design must drop the set pulses and clear those flags, and the inexact bit must keep its old value when its enable bit is clear. To get there, the bench first drives set pulses to load the flags. It then issues directed updates with set pulses asserted in the same cycle, with all enables cleared, and with values present but enables missing. Random cycles then mix updates and set pulses, each at about half density, so this collision recurs many times.

// File: rtl/fpu_flag_pkg.sv
package fpu_flag_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_FLAGS = 5;   // underflow..summary
  localparam int unsigned VAL_LSB   = 3;
  localparam int unsigned MASK_LSB  = 11;
  localparam int unsigned FX_VAL    = 2;
  localparam int unsigned FX_EN     = 10;
  localparam int unsigned SUM_IDX   = NUM_FLAGS - 1;
  localparam int unsigned NUM_EXC   = NUM_FLAGS - 1;
endpackage

// File: rtl/fpu_flag_upd_decode.sv
module fpu_flag_upd_decode
  import fpu_flag_pkg::*;
(
  input  logic [WORD_W-1:0]    word_i,
  output logic [NUM_FLAGS-1:0] load_o,
  output logic                 fx_en_o,
  output logic                 fx_val_o
);
  always_comb begin
    load_o   = word_i[VAL_LSB +: NUM_FLAGS] & word_i[MASK_LSB +: NUM_FLAGS];
    fx_en_o  = word_i[FX_EN];
    fx_val_o = word_i[FX_VAL];
  end
endmodule

// File: rtl/fpu_flag_cell.sv
module fpu_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic ld_en_i,
  input  logic ld_val_i,
  input  logic set_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    if (upd_i) q_d = ld_en_i ? ld_val_i : q_o;
    else       q_d = q_o | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end

  a_r8_upd_ignores_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ld_en_i) |=> $stable(q_o));
endmodule

// File: rtl/fpu_status_flags.sv
module fpu_status_flags
  import fpu_flag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_valid_i,
  input  logic [WORD_W-1:0]    upd_word_i,
  input  logic [NUM_EXC-1:0]   exc_set_i,
  input  logic                 inexact_set_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 inexact_o
);
  logic [NUM_FLAGS-1:0] load;
  logic                 fx_en, fx_val;
  logic                 any_set;

  fpu_flag_upd_decode i_dec (
    .word_i  (upd_word_i),
    .load_o  (load),
    .fx_en_o (fx_en),
    .fx_val_o(fx_val)
  );

  assign any_set = (|exc_set_i) | inexact_set_i;

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    logic set_k;
    if (k == SUM_IDX) begin : g_sum
      assign set_k = any_set;
    end else begin : g_exc
      assign set_k = exc_set_i[k];
    end
    fpu_flag_cell i_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_i   (upd_valid_i),
      .ld_en_i (1'b1),
      .ld_val_i(load[k]),
      .set_i   (set_k),
      .q_o     (flags_o[k])
    );
  end

  fpu_flag_cell i_fx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd_valid_i),
    .ld_en_i (fx_en),
    .ld_val_i(fx_val),
    .set_i   (inexact_set_i),
    .q_o     (inexact_o)
  );

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> (flags_o == '0 && !inexact_o));
  a_r2_masked_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> flags_o == ($past(upd_word_i[VAL_LSB +: NUM_FLAGS]) &
                                $past(upd_word_i[MASK_LSB +: NUM_FLAGS])));
  a_r4_fx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_word_i[FX_EN]) |=> inexact_o == $past(upd_word_i[FX_VAL]));
  a_r5_fx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_word_i[FX_EN]) |=> $stable(inexact_o));
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (flags_o & $past(flags_o)) == $past(flags_o));
  a_r7_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && ((|exc_set_i) || inexact_set_i)) |=> flags_o[SUM_IDX]);
endmodule

// File: tb/test_fpu_status_flags.sv
module test_fpu_status_flags;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [31:0] word = '0;
  logic [3:0]  exc = '0;
  logic        ixs = 1'b0;
  logic [4:0]  flags;
  logic        ix;

  int errors = 0;
  int checks = 0;
  logic [4:0] m_flags = '0;
  logic       m_ix = 1'b0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_status_flags i_fpu_status_flags (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd), .upd_word_i(word),
    .exc_set_i(exc), .inexact_set_i(ixs), .flags_o(flags), .inexact_o(ix)
  );

  function automatic logic [4:0] nxt_flags(logic [4:0] cur, logic u, logic [31:0] w,
                                           logic [3:0] e, logic s);
    if (u) return w[7:3] & w[15:11];
    return cur | {(|e) | s, e};
  endfunction

  function automatic logic nxt_ix(logic cur, logic u, logic [31:0] w, logic s);
    if (u) return w[10] ? w[2] : cur;
    return cur | s;
  endfunction

  task automatic check(string tag);
    checks++;
    if (flags !== m_flags) begin
      errors++;
      $display("FAIL %s flags actual=%b expected=%b", tag, flags, m_flags);
    end
    checks++;
    if (ix !== m_ix) begin
      errors++;
      $display("FAIL %s inexact actual=%b expected=%b", tag, ix, m_ix);
    end
  endtask

  // drive one cycle, then check the result at the following negedge
  task automatic cyc(logic u, logic [31:0] w, logic [3:0] e, logic s, string tag);
    upd = u; word = w; exc = e; ixs = s;
    m_flags = nxt_flags(m_flags, u, w, e, s);
    m_ix    = nxt_ix(m_ix, u, w, s);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    cyc(1'b0, '0, 4'b0101, 1'b0, "R6 R7 set underflow/overflow");
    cyc(1'b0, '0, 4'b0000, 1'b1, "R6 R7 inexact set");
    cyc(1'b0, '0, 4'b0000, 1'b0, "R6 hold");
    // values without enables: all five cleared, inexact kept
    cyc(1'b1, 32'h0000_00FC, 4'b1111, 1'b1, "R3 R5 R8 no enables");
    cyc(1'b1, 32'h0000_FF00, 4'b0000, 1'b0, "R3 R4 enables without values");
    cyc(1'b1, 32'h0000_FFFC, 4'b0000, 1'b0, "R2 R4 load all");
    cyc(1'b1, 32'h0000_AA54, 4'b1010, 1'b1, "R2 R8 partial");
    cyc(1'b1, 32'hFFFF_0303, 4'b0000, 1'b0, "R9 unused bits");
    cyc(1'b1, 32'h0000_0400, 4'b0000, 1'b0, "R4 inexact clear");
    cyc(1'b0, '0, 4'b1000, 1'b0, "R7 invalid sets summary");
    for (int i = 0; i < 2000; i++) begin
      logic u;
      u = ($urandom % 2) == 0;
      cyc(u, $urandom, 4'($urandom), 1'($urandom), u ? "R2 R4 R5 R8 random upd" : "R6 R7 random set");
    end
    rst_n = 1'b0; m_flags = '0; m_ix = 1'b0;
    #1;
    check("R1 async reset");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule